// File: doc/BRIEF.md
# Control-Line Bit-Slice ALU

This block is an arithmetic and logic unit of configurable width (eight bits by default) built as a row of identical bit slices. It does not compute every candidate result and then pick one. Each slice forms a single gate-level value from its two operand bits. It then XORs that value with a per-bit carry line. That line is either held at a constant or rippled from the slice below, and it turns the gate value into the requested OR, XOR, AND, sum or difference. Five independent control lines choose the operation directly. No opcode field has to be decoded.

The operands are `a` and `x`. There is a carry-in for bit 0 and a shift-in bit that enters the top position on a right shift. Two flags are derived from the result: even parity and all-zero. The result, the carry-out and both flags pass through one output register stage, clocked by `clk` and reset asynchronously by the active-low `rst_n`. Each output therefore reflects the inputs sampled at the previous rising edge.

Top module: `alu_core`

## Requirements
- R1: With the control lines {inv_x, op_nand, op_block, shift_en, carry_force} = 01000, `result` is the low WIDTH bits of a + x + cin and `carry_out` is bit WIDTH of that sum.
- R2: With controls 11000, `result` is the low WIDTH bits of a + ~x + cin and `carry_out` is bit WIDTH of that sum, so 1 means no borrow.
- R3: With controls 00001, `result` is a | x.
- R4: With controls 01001, `result` is a ^ x.
- R5: With controls 01101, `result` is a & x.
- R6: With controls 10001, `result` is a | ~x.
- R7: With controls 00111, `result` is {shift_in, a[WIDTH-1:1]}.
- R8: For the five encodings of R3 to R7, `cin` has no effect on `result` and `carry_out` is 0.
- R9: `parity` is 1 exactly when `result` holds an even number of ones.
- R10: `zero` is 1 exactly when every bit of `result` is 0.
- R11: All outputs change only at a rising clock edge, one cycle after the inputs they reflect.
- R12: While `rst_n` is low, `result` and `carry_out` are 0 and `parity` and `zero` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | WIDTH | First operand |
| x | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| shift_in | input | 1 | Bit shifted into the top position |
| inv_x | input | 1 | Invert the second operand inside each slice |
| op_nand | input | 1 | Enable the NAND term of the slice gate |
| op_block | input | 1 | Block the OR term and force carry lines to 0 |
| shift_en | input | 1 | Take each result bit from the next higher A bit |
| carry_force | input | 1 | Force carry lines to 1 when not blocked |
| result | output | WIDTH | Registered result |
| carry_out | output | 1 | Registered true carry out of the top bit |
| parity | output | 1 | Registered even-parity flag |
| zero | output | 1 | Registered all-zero flag |

## Verification
A fault in the carry chain can be wrong in one slice only. For sums it shows up in the bits above that slice and in `carry_out`. For the logic encodings it shows up wherever a forced line value is wrong. Either way it appears at the register output one cycle after the operands are applied. Because the result passes straight through the output register, each random operand pair under every encoding exposes that defect on the very next edge. Walking carries such as 0xFF + 1 and equal-operand differences show it in `zero` and `carry_out` at the same time.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic inv_x;
        logic op_nand;
        logic op_block;
        logic shift_en;
        logic carry_force;
    } ctrl_t;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  ctrl_t ctl,
    input  logic  a_bit,
    input  logic  x_bit,
    input  logic  up_bit,
    input  logic  line_in,
    output logic  res_bit,
    output logic  line_out
);
    logic xe, t1, t2, opv, gen;

    always_comb begin
        xe       = x_bit ^ ctl.inv_x;
        t1       = ctl.op_nand ? ~(a_bit & xe) : 1'b1;
        t2       = ctl.op_block ? 1'b1 : (a_bit | xe);
        opv      = ~(t1 & t2);
        res_bit  = (opv ^ line_in) | (ctl.shift_en & up_bit);
        // line_in carries the inverted true carry when rippling
        gen      = (a_bit & xe) | (~line_in & (a_bit | xe));
        if (ctl.op_block)
            line_out = 1'b0;
        else if (ctl.carry_force)
            line_out = 1'b1;
        else
            line_out = ~gen;
    end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] value,
    output logic             parity,
    output logic             zero
);
    always_comb begin
        parity = ~(^value);
        zero   = ~(|value);
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] x,
    input  logic             cin,
    input  logic             shift_in,
    input  logic             inv_x,
    input  logic             op_nand,
    input  logic             op_block,
    input  logic             shift_en,
    input  logic             carry_force,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             parity,
    output logic             zero
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             cout;
        logic             par;
        logic             zro;
    } out_t;

    ctrl_t            ctl;
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] a_up;
    logic [WIDTH-1:0] res_w;
    logic             par_w, zro_w;
    out_t             out_d, out_q;

    assign ctl      = '{inv_x: inv_x, op_nand: op_nand, op_block: op_block,
                        shift_en: shift_en, carry_force: carry_force};
    assign a_up     = {shift_in, a[MSB:1]};
    // Bit 0 sees the same forcing rule as any slice, fed by the external carry
    assign chain[0] = op_block ? 1'b0 : (carry_force ? 1'b1 : ~cin);

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_slice u_slice (
            .ctl     (ctl),
            .a_bit   (a[i]),
            .x_bit   (x[i]),
            .up_bit  (a_up[i]),
            .line_in (chain[i]),
            .res_bit (res_w[i]),
            .line_out(chain[i+1])
        );
    end

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .value (res_w),
        .parity(par_w),
        .zero  (zro_w)
    );

    always_comb begin
        out_d.res  = res_w;
        out_d.cout = ~(op_block | carry_force) & ~chain[WIDTH];
        out_d.par  = par_w;
        out_d.zro  = zro_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '{res: '0, cout: 1'b0, par: 1'b1, zro: 1'b1};
        else
            out_q <= out_d;
    end

    assign result    = out_q.res;
    assign carry_out = out_q.cout;
    assign parity    = out_q.par;
    assign zero      = out_q.zro;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] x,
    input logic             cin,
    input logic             shift_in,
    input logic             inv_x,
    input logic             op_nand,
    input logic             op_block,
    input logic             shift_en,
    input logic             carry_force,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             parity,
    input logic             zero
);
    logic [4:0] enc;
    logic       past_ok;

    assign enc = {inv_x, op_nand, op_block, shift_en, carry_force};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(enc) == 5'b01000) |->
        ({carry_out, result} == ({1'b0, $past(a)} + {1'b0, $past(x)} + (WIDTH+1)'($past(cin)))));

    // R2
    sub_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(enc) == 5'b11000) |->
        ({carry_out, result} == ({1'b0, $past(a)} + {1'b0, ~$past(x)} + (WIDTH+1)'($past(cin)))));

    // R3
    or_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(enc) == 5'b00001) |-> (result == ($past(a) | $past(x))));

    // R4
    xor_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(enc) == 5'b01001) |-> (result == ($past(a) ^ $past(x))));

    // R5
    and_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(enc) == 5'b01101) |-> (result == ($past(a) & $past(x))));

    // R6
    orn_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(enc) == 5'b10001) |-> (result == ($past(a) | ~$past(x))));

    // R7
    shr_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(enc) == 5'b00111) |->
        (result == {$past(shift_in), $past(a[WIDTH-1:1])}));

    // R8
    logic_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(enc) != 5'b01000 && $past(enc) != 5'b11000) |-> !carry_out);

    // R9
    parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parity == ($countones(result) % 2 == 0));

    // R10
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero == (result == '0));
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_alu_core.sv
module sim_alu_core;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    localparam logic [4:0] E_OR  = 5'b00001;
    localparam logic [4:0] E_ADD = 5'b01000;
    localparam logic [4:0] E_XOR = 5'b01001;
    localparam logic [4:0] E_AND = 5'b01101;
    localparam logic [4:0] E_SHR = 5'b00111;
    localparam logic [4:0] E_ORN = 5'b10001;
    localparam logic [4:0] E_SUB = 5'b11000;

    // {enc, a, x, cin, shift_in}
    localparam logic [22:0] VEC [0:11] = '{
        {E_ADD, 8'h50, 8'h10, 1'b0, 1'b0},
        {E_ADD, 8'h50, 8'h50, 1'b1, 1'b0},
        {E_ADD, 8'hD0, 8'hD0, 1'b0, 1'b0},
        {E_SUB, 8'h50, 8'h70, 1'b1, 1'b0},
        {E_SUB, 8'h50, 8'hF0, 1'b0, 1'b0},
        {E_OR,  8'hA5, 8'h0F, 1'b0, 1'b0},
        {E_XOR, 8'hFF, 8'h3C, 1'b1, 1'b0},
        {E_AND, 8'hC3, 8'h5A, 1'b0, 1'b0},
        {E_ORN, 8'h00, 8'hF0, 1'b1, 1'b0},
        {E_SHR, 8'h81, 8'h00, 1'b0, 1'b1},
        {E_SHR, 8'hFE, 8'hFF, 1'b1, 1'b0},
        {E_ORN, 8'h12, 8'h34, 1'b0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0, x = '0;
    logic         cin = 1'b0, shift_in = 1'b0;
    logic [4:0]   enc = E_OR;
    logic [W-1:0] result;
    logic         carry_out, parity, zero;
    int           checks = 0;
    int           errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_core #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .a(a), .x(x), .cin(cin), .shift_in(shift_in),
        .inv_x(enc[4]), .op_nand(enc[3]), .op_block(enc[2]),
        .shift_en(enc[1]), .carry_force(enc[0]),
        .result(result), .carry_out(carry_out), .parity(parity), .zero(zero)
    );

    function automatic logic [W:0] ref_f(logic [4:0] e, logic [W-1:0] ra, logic [W-1:0] rx,
                                         logic rc, logic rs);
        case (e)
            E_ADD:   return {1'b0, ra} + {1'b0, rx} + (W+1)'(rc);
            E_SUB:   return {1'b0, ra} + {1'b0, ~rx} + (W+1)'(rc);
            E_OR:    return {1'b0, ra | rx};
            E_XOR:   return {1'b0, ra ^ rx};
            E_AND:   return {1'b0, ra & rx};
            E_ORN:   return {1'b0, ra | ~rx};
            default: return {1'b0, rs, ra[W-1:1]};
        endcase
    endfunction

    function automatic string tag_of(logic [4:0] e);
        case (e)
            E_ADD:   return "R1";
            E_SUB:   return "R2";
            E_OR:    return "R3";
            E_XOR:   return "R4";
            E_AND:   return "R5";
            E_ORN:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check_out(string tag, logic [W:0] exp9);
        logic exp_par, exp_zro;
        exp_par = ($countones(exp9[W-1:0]) % 2) == 0;
        exp_zro = (exp9[W-1:0] == '0);
        checks++;
        if ({carry_out, result} !== exp9) begin
            errors++;
            $display("FAIL %s: carry/result actual %b/%h expected %b/%h",
                     tag, carry_out, result, exp9[W], exp9[W-1:0]);
        end
        checks++;
        if (parity !== exp_par) begin
            errors++;
            $display("FAIL R9 (%s): parity actual %b expected %b", tag, parity, exp_par);
        end
        checks++;
        if (zero !== exp_zro) begin
            errors++;
            $display("FAIL R10 (%s): zero actual %b expected %b", tag, zero, exp_zro);
        end
    endtask

    task automatic apply(logic [4:0] e, logic [W-1:0] va, logic [W-1:0] vx, logic vc, logic vs);
        @(negedge clk);
        enc = e; a = va; x = vx; cin = vc; shift_in = vs;
        @(posedge clk);
        #1;
    endtask

    task automatic run(string tag, logic [4:0] e, logic [W-1:0] va, logic [W-1:0] vx,
                       logic vc, logic vs);
        apply(e, va, vx, vc, vs);
        check_out(tag, ref_f(e, va, vx, vc, vs));
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [4:0] encs [0:6];
        encs = '{E_OR, E_ADD, E_XOR, E_AND, E_SHR, E_ORN, E_SUB};

        // R12: reset state with busy inputs
        enc = E_ADD; a = 8'hFF; x = 8'h01; cin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out("R12", 9'h000);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < 12; i++) begin
            logic [4:0] e;
            e = VEC[i][22:18];
            run(tag_of(e), e, VEC[i][17:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // Random operands under every encoding
        for (int k = 0; k < 7; k++) begin
            for (int n = 0; n < 30; n++) begin
                run(tag_of(encs[k]), encs[k], W'($urandom), W'($urandom),
                    1'($urandom), 1'($urandom));
            end
        end

        // R8: carry-in ignored for logic encodings
        for (int k = 0; k < 7; k++) begin
            if (encs[k] != E_ADD && encs[k] != E_SUB) begin
                run("R8", encs[k], 8'h6B, 8'hD4, 1'b0, 1'b1);
                run("R8", encs[k], 8'h6B, 8'hD4, 1'b1, 1'b1);
            end
        end

        // R10 / R1 / R2: carry through every bit and equal operands
        run("R1", E_ADD, 8'hFF, 8'h01, 1'b0, 1'b0);
        run("R1", E_ADD, 8'hFF, 8'h00, 1'b1, 1'b0);
        run("R2", E_SUB, 8'h37, 8'h37, 1'b1, 1'b0);
        run("R2", E_SUB, 8'h00, 8'h01, 1'b1, 1'b0);
        // R9: odd and even counts
        run("R9", E_XOR, 8'h01, 8'h00, 1'b0, 1'b0);
        run("R9", E_XOR, 8'h03, 8'h00, 1'b0, 1'b0);
        // R7: shift-in both values
        run("R7", E_SHR, 8'h00, 8'h00, 1'b0, 1'b1);
        run("R7", E_SHR, 8'h01, 8'h00, 1'b1, 1'b0);

        // R11: outputs hold until the next rising edge
        run("R11", E_ADD, 8'h01, 8'h02, 1'b0, 1'b0);
        @(negedge clk);
        enc = E_ADD; a = 8'h05; x = 8'h05; cin = 1'b0;
        #1;
        check_out("R11", 9'h003);
        @(posedge clk);
        #1;
        check_out("R11", 9'h00A);

        // R12: asynchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_out("R12", 9'h000);
        rst_n = 1'b1;

        finish_up();
    end
endmodule